// File: doc/BRIEF.md
# Partial Input Isolation Ring

This block is a test wrapper that sits between user logic and the inputs of a black-box core. A compile-time mask selects which core inputs carry a ring cell. Each ring cell holds one flip-flop. A scan-select mux in front of the flip-flop chooses between the serial path and the capture path. A test mux behind it chooses whether the core input sees the flip-flop or the user-logic value. Core inputs without a cell get no mux and no flip-flop, so their user-logic output drives the core directly. In test, their patterns have to be justified through the user logic.

The user-logic outputs on unringed inputs must still be observable. Each one is folded by a two-input XOR into the capture path of one chosen ringed cell, so a design with n inputs and k cells spends exactly n − k XOR gates on this compaction. The cells form one serial chain, which can be joined to a core's own internal chain so that one shift sequence loads both. Elaboration stops with an error in two cases: when the mask leaves no ringed cell, or when a fold target is not itself a ringed input.

Top module: `partial_input_ring`

## Requirements
- R1: A core input without a ring cell always equals its user-logic output, in every mode and for every scan state.
- R2: While `testMode` is 0, every bit of `coreIn` equals the same bit of `udlOut`.
- R3: While `testMode` is 1, each ringed core input shows the current content of its own ring cell.
- R4: On a clock edge with `shiftEn` at 1, the bit on `scanIn` enters the cell of the lowest-index ringed input. Every other cell takes the value of the next lower ringed cell. `scanOut` is the cell of the highest-index ringed input. A bit shifted in first therefore reaches `scanOut` after k shifts.
- R5: On a clock edge with `captureEn` at 1 and `shiftEn` at 0, each cell loads its own user-logic bit XORed with the user-logic bits of every unringed input folded into it. In the default build, inputs 0, 2, 4, 5 and 7 are ringed. The cells capture u0^u1, u2^u3, u4, u5 and u7^u6.
- R6: When `shiftEn` and `captureEn` are both 1, the ring shifts and the capture does not take place.
- R7: With both `shiftEn` and `captureEn` at 0, every cell keeps its value, whatever `udlOut` and `scanIn` do.
- R8: An active-low asynchronous `rst_n` clears every ring cell to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Test clock for the ring cells |
| rst_n | input | 1 | Asynchronous reset, active low |
| testMode | input | 1 | 1 drives ringed core inputs from their cells |
| shiftEn | input | 1 | Serial shift through the ring |
| captureEn | input | 1 | Parallel load of compacted user-logic outputs |
| scanIn | input | 1 | Serial data into the lowest ringed cell |
| udlOut | input | N | Outputs of the user logic driving the core |
| scanOut | output | 1 | Content of the highest ringed cell |
| coreIn | output | N | Inputs delivered to the core |

## Verification
Shift and capture can be requested on the same edge. The bench provokes this by loading a known pattern, presenting an all-ones user-logic word, and raising both enables for one cycle. Shifted and captured contents differ in several cells. The result is judged by reading the cells through the test-mode core inputs, which must show the shifted pattern and not the captured one.

// File: rtl/partial_input_ring_pkg.sv
package partial_input_ring_pkg;

  // Strobes from the control decode to the ring datapath.
  typedef struct packed {
    logic shift;
    logic capture;
  } ringStrobe_t;

  // Width of one fold-target field in the fold map parameter.
  localparam int FOLD_FIELD_W = 8;

endpackage

// File: rtl/partial_input_ring_ctrl.sv
module partial_input_ring_ctrl
  import partial_input_ring_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        shiftEn,
  input  logic        captureEn,
  output ringStrobe_t strobe
);

  // Shift has priority; capture only happens on a non-shift edge.
  always_comb begin
    strobe.shift   = shiftEn;
    strobe.capture = captureEn & ~shiftEn;
  end

  // R6: at most one operation is issued per edge.
  assert_one_op_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({strobe.shift, strobe.capture}));

endmodule

// File: rtl/partial_input_ring_dp.sv
module partial_input_ring_dp
  import partial_input_ring_pkg::*;
#(
  parameter int                           N         = 8,
  parameter logic [N-1:0]                 RING_MASK = 8'b1011_0101,
  parameter logic [FOLD_FIELD_W*N-1:0]    FOLD_MAP  = 64'h0707_0504_0202_0000
)(
  input  logic          clk,
  input  logic          rst_n,
  input  ringStrobe_t   strobe,
  input  logic          testMode,
  input  logic          scanIn,
  input  logic [N-1:0]  udlOut,
  output logic          scanOut,
  output logic [N-1:0]  coreIn
);

  // Number of ringed inputs.
  function automatic int ringCount();
    int cnt = 0;
    for (int i = 0; i < N; i++) if (RING_MASK[i]) cnt++;
    return cnt;
  endfunction

  // Chain position of ringed input idx (count of ringed inputs below it).
  function automatic int rankOf(int idx);
    int cnt = 0;
    for (int i = 0; i < N; i++) if (RING_MASK[i] && i < idx) cnt++;
    return cnt;
  endfunction

  // Input index of the ringed cell at chain position r.
  function automatic int posOfRank(int r);
    int cnt = 0;
    int pos = 0;
    for (int i = 0; i < N; i++) begin
      if (RING_MASK[i]) begin
        if (cnt == r) pos = i;
        cnt++;
      end
    end
    return pos;
  endfunction

  // Set of unringed inputs whose response is folded into input tgt.
  function automatic logic [N-1:0] foldSet(int tgt);
    logic [N-1:0] fs = '0;
    for (int j = 0; j < N; j++) begin
      if (!RING_MASK[j] &&
          int'(FOLD_MAP[FOLD_FIELD_W*j +: FOLD_FIELD_W]) == tgt)
        fs[j] = 1'b1;
    end
    return fs;
  endfunction

  localparam int K = ringCount();

  // Elaboration guards.
  if (K < 1) begin : g_no_cells
    $error("partial_input_ring: RING_MASK selects no ring cell");
  end

  for (genvar j = 0; j < N; j++) begin : g_fold_chk
    localparam int TGT = int'(FOLD_MAP[FOLD_FIELD_W*j +: FOLD_FIELD_W]);
    if (!RING_MASK[j] && (TGT >= N || !RING_MASK[TGT % N])) begin : g_bad
      $error("partial_input_ring: fold target of an unringed input is not ringed");
    end
  end

  logic [K-1:0] ringQ;
  logic [K-1:0] captureVal;
  logic [K-1:0] shiftSrc;

  // Per-cell capture (own bit plus folded XOR) and serial source.
  for (genvar r = 0; r < K; r++) begin : g_cell
    localparam int           POS = posOfRank(r);
    localparam logic [N-1:0] FS  = foldSet(POS);

    assign captureVal[r] = udlOut[POS] ^ (^(udlOut & FS));

    if (r == 0) begin : g_head
      assign shiftSrc[r] = scanIn;
    end else begin : g_link
      assign shiftSrc[r] = ringQ[r-1];
    end
  end

  // Ring flip-flops: scan-select mux folded into the next-state choice.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              ringQ <= '0;
    else if (strobe.shift)   ringQ <= shiftSrc;
    else if (strobe.capture) ringQ <= captureVal;
  end

  assign scanOut = ringQ[K-1];

  // Core-side muxing: test mux only where a cell exists.
  for (genvar i = 0; i < N; i++) begin : g_core
    if (RING_MASK[i]) begin : g_ringed
      localparam int RK = rankOf(i);
      assign coreIn[i] = testMode ? ringQ[RK] : udlOut[i];
    end else begin : g_direct
      assign coreIn[i] = udlOut[i];
    end
  end

  // R7: idle edges keep the ring content.
  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!strobe.shift && !strobe.capture) |=> $stable(ringQ));

  // R4: serial input lands in the first cell.
  assert_shift_entry_R4: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.shift |=> (ringQ[0] == $past(scanIn)));

  // R4: scanOut takes the previous second-to-last cell on a shift.
  if (K > 1) begin : g_out_chk
    assert_shift_out_R4: assert property (@(posedge clk) disable iff (!rst_n)
      strobe.shift |=> (scanOut == $past(ringQ[K-2])));
  end

  // R2: functional mode is transparent.
  assert_transparent_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !testMode |-> (coreIn == udlOut));

endmodule

// File: rtl/partial_input_ring.sv
module partial_input_ring
  import partial_input_ring_pkg::*;
#(
  parameter int                        N         = 8,
  parameter logic [N-1:0]              RING_MASK = 8'b1011_0101,
  parameter logic [FOLD_FIELD_W*N-1:0] FOLD_MAP  = 64'h0707_0504_0202_0000
)(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         testMode,
  input  logic         shiftEn,
  input  logic         captureEn,
  input  logic         scanIn,
  input  logic [N-1:0] udlOut,
  output logic         scanOut,
  output logic [N-1:0] coreIn
);

  ringStrobe_t strobe;

  partial_input_ring_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .shiftEn   (shiftEn),
    .captureEn (captureEn),
    .strobe    (strobe)
  );

  partial_input_ring_dp #(
    .N         (N),
    .RING_MASK (RING_MASK),
    .FOLD_MAP  (FOLD_MAP)
  ) u_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .strobe   (strobe),
    .testMode (testMode),
    .scanIn   (scanIn),
    .udlOut   (udlOut),
    .scanOut  (scanOut),
    .coreIn   (coreIn)
  );

endmodule

// File: tb/partial_input_ring_tb.sv
`timescale 1ns/1ps
module partial_input_ring_tb;

  localparam logic [7:0] MASK = 8'b1011_0101;  // ringed: 0,2,4,5,7

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       testMode = 1'b0;
  logic       shiftEn = 1'b0;
  logic       captureEn = 1'b0;
  logic       scanIn = 1'b0;
  logic [7:0] udlOut = 8'h00;
  logic       scanOut;
  logic [7:0] coreIn;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  partial_input_ring #(
    .N         (8),
    .RING_MASK (MASK),
    .FOLD_MAP  (64'h0707_0504_0202_0000)
  ) u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .testMode  (testMode),
    .shiftEn   (shiftEn),
    .captureEn (captureEn),
    .scanIn    (scanIn),
    .udlOut    (udlOut),
    .scanOut   (scanOut),
    .coreIn    (coreIn)
  );

  // {udlOut, expected cells c4..c0} per R5: c0=u0^u1 c1=u2^u3 c2=u4 c3=u5 c4=u7^u6
  localparam logic [12:0] VEC [10] = '{
    {8'h00, 5'b00000},
    {8'hFF, 5'b01100},
    {8'h01, 5'b00001},
    {8'h02, 5'b00001},
    {8'h0C, 5'b00000},
    {8'h08, 5'b00010},
    {8'h40, 5'b10000},
    {8'hA5, 5'b11011},
    {8'h5A, 5'b10111},
    {8'h30, 5'b01100}
  };

  // Expected core inputs in test mode: ringed positions show cells in order.
  function automatic logic [7:0] expCore(logic [7:0] udl, logic [4:0] cells);
    logic [7:0] o;
    int r = 0;
    for (int i = 0; i < 8; i++) begin
      if (MASK[i]) begin
        o[i] = cells[r];
        r++;
      end else begin
        o[i] = udl[i];
      end
    end
    return o;
  endfunction

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    // Reset state (R8), unringed pass-through (R1), transparency (R2)
    udlOut = 8'hFF;
    testMode = 1'b1;
    #1;
    check("R8 reset cells via coreIn", coreIn, expCore(8'hFF, 5'b00000));
    check("R8 reset scanOut", {7'b0, scanOut}, 8'h00);
    testMode = 1'b0;
    #1;
    check("R2 reset transparency", coreIn, 8'hFF);
    step();
    rst_n = 1'b1;
    step();

    // Table walk: capture (R5), apply (R3), unringed (R1), unload (R4)
    for (int v = 0; v < 10; v++) begin
      udlOut    = VEC[v][12:5];
      testMode  = 1'b0;
      captureEn = 1'b1;
      step();
      captureEn = 1'b0;
      check("R2 functional coreIn", coreIn, udlOut);
      testMode = 1'b1;
      #1;
      check("R3 R5 R1 captured cells on coreIn", coreIn, expCore(udlOut, VEC[v][4:0]));
      for (int b = 4; b >= 0; b--) begin
        check("R4 scanOut unload order", {7'b0, scanOut}, {7'b0, VEC[v][b]});
        scanIn  = 1'b0;
        shiftEn = 1'b1;
        step();
      end
      shiftEn = 1'b0;
      check("R4 ring flushed with zeros", coreIn, expCore(udlOut, 5'b00000));
    end

    // Shift order (R4): first bit in ends in highest cell
    udlOut   = 8'h00;
    testMode = 1'b1;
    begin
      logic [4:0] seq;
      seq = 5'b01011;  // seq[0] shifted first: 1,1,0,1,0
      for (int s = 0; s < 5; s++) begin
        scanIn  = seq[s];
        shiftEn = 1'b1;
        step();
      end
    end
    shiftEn = 1'b0;
    check("R4 shift-in order", coreIn, expCore(8'h00, 5'b11010));
    check("R4 scanOut after load", {7'b0, scanOut}, 8'h01);

    // Shift and capture together (R6): shifted 10100, not captured 01100
    udlOut    = 8'hFF;
    scanIn    = 1'b0;
    shiftEn   = 1'b1;
    captureEn = 1'b1;
    step();
    shiftEn   = 1'b0;
    captureEn = 1'b0;
    check("R6 shift wins over capture", coreIn, expCore(8'hFF, 5'b10100));

    // Hold (R7): inputs wiggle, no strobe
    udlOut = 8'h3C;
    scanIn = 1'b1;
    step();
    udlOut = 8'hC3;
    step();
    udlOut = 8'h3C;
    step();
    check("R7 hold cells", coreIn, expCore(8'h3C, 5'b10100));
    check("R7 hold scanOut", {7'b0, scanOut}, 8'h01);

    // Mid-run asynchronous reset (R8)
    rst_n = 1'b0;
    #1;
    check("R8 async clear", coreIn, expCore(8'h3C, 5'b00000));
    testMode = 1'b0;
    #1;
    check("R2 transparency in reset", coreIn, 8'h3C);
    step();
    rst_n = 1'b1;
    step();

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule